// File: doc/BRIEF.md
# Memory controller test control and fault injection

This block sits beside the error-correction datapath of a memory controller and lets software inject faults on purpose. Two configuration registers are written through a simple write port. The first holds a checkbit-override enable, a read-parity corruption enable and a checkbit override field. The second holds a software "system available" flag.

Store traffic (data plus the checkbits produced by the error-correction encoder) flows through the block on a valid/ready stream. When the override is enabled, the outgoing checkbits are replaced by the programmed field, so that known-bad codewords reach memory. Register read data flows through a second valid/ready stream, where the block appends an odd parity bit. When corruption is enabled, that bit is inverted.

Both streams are pure flow-through stages with no storage. A beat moves when valid and ready are both high on the downstream side. The upstream ready is the downstream ready, unchanged. The upstream valid is passed on, unchanged. Back-pressure therefore propagates in the same cycle, and no beat is dropped or duplicated. The availability output combines the software flag with the active-low system error input.

Top module: `memtest_ctl`

## Requirements
- R1: After reset the override enable, the corruption enable, the override field and the system-available flag are all 0, and `avail_o` is 0.
- R2: `avail_o` is registered. After each rising clock edge it equals (system-available flag AND `sys_err_n`), both taken before that edge.
- R3: While the override enable is 1, every store beat leaves with `st_out_cb` equal to the programmed override field.
- R4: While the override enable is 0, `st_out_cb` equals `st_in_cb`.
- R5: The store stream is flow-through. `st_out_valid` equals `st_in_valid`, `st_in_ready` equals `st_out_ready`, and `st_out_data` equals `st_in_data` in every mode.
- R6: While the corruption enable is 0, `rd_out_par` makes the 33 bits {`rd_out_data`, `rd_out_par`} hold an odd number of ones.
- R7: While the corruption enable is 1, `rd_out_par` is the inverse of the odd parity bit, and `rd_out_data` still equals `rd_in_data`.
- R8: The read stream is flow-through. `rd_out_valid` equals `rd_in_valid`, and `rd_in_ready` equals `rd_out_ready`.
- R9: Register layout:
  - A write to address 0 (`cfg_addr`=0) with `cfg_we`=1 loads the override enable from bit 0, the corruption enable from bit 1 and the override field from bits 14:8. It leaves the system-available flag unchanged.
  - A write to address 1 loads the system-available flag from bit 0 and leaves address 0 unchanged.
  - With `cfg_we`=0, no register changes.
  - All writes take effect at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 test control, 1 availability |
| cfg_wdata | input | 32 | Register write data |
| sys_err_n | input | 1 | System error, active low |
| avail_o | output | 1 | System available, active high, registered |
| st_in_valid | input | 1 | Store beat valid from encoder |
| st_in_ready | output | 1 | Store beat accepted |
| st_in_data | input | 32 | Store data |
| st_in_cb | input | 7 | Checkbits from the encoder |
| st_out_valid | output | 1 | Store beat valid toward memory |
| st_out_ready | input | 1 | Memory side ready |
| st_out_data | output | 32 | Store data toward memory |
| st_out_cb | output | 7 | Checkbits toward memory |
| rd_in_valid | input | 1 | Register read data valid |
| rd_in_ready | output | 1 | Register read data accepted |
| rd_in_data | input | 32 | Register read data |
| rd_out_valid | output | 1 | Read beat valid toward the bus |
| rd_out_ready | input | 1 | Bus side ready |
| rd_out_data | output | 32 | Read data toward the bus |
| rd_out_par | output | 1 | Read parity bit |

## Verification
The bench builds the block with its default widths: 32 data bits, a 7-bit checkbit field and a 32-bit register word. At these widths random writes can reach every one of the 128 override field values and both enables in any mix. Random 32-bit read words give both parity outcomes in each parity mode. Directed writes with stray bits set outside the defined fields, and writes with the strobe low, reach the decode corners of R9. Toggling `sys_err_n` while the flag is set reaches the gating of R2.

// File: rtl/memtest_ctl_pkg.sv
package memtest_ctl_pkg;
  localparam int unsigned TC_ADDR_W = 1;

  typedef enum logic [TC_ADDR_W-1:0] {
    TC_ADDR_CTRL  = 1'b0,
    TC_ADDR_AVAIL = 1'b1
  } tc_addr_e;

  localparam int unsigned TC_EDAC_BIT  = 0;
  localparam int unsigned TC_PAR_BIT   = 1;
  localparam int unsigned TC_CB_LSB    = 8;
  localparam int unsigned TC_AVAIL_BIT = 0;
endpackage

// File: rtl/memtest_ctl_regs.sv
module memtest_ctl_regs
  import memtest_ctl_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned CB_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             edac_en,
  output logic             par_en,
  output logic [CB_W-1:0]  cb_field,
  output logic             sysav
);
  localparam int unsigned CB_MSB = TC_CB_LSB + CB_W - 1;

  logic wr_ctrl, wr_avail;
  assign wr_ctrl  = cfg_we && (cfg_addr == TC_ADDR_CTRL);
  assign wr_avail = cfg_we && (cfg_addr == TC_ADDR_AVAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edac_en  <= 1'b0;
      par_en   <= 1'b0;
      cb_field <= '0;
    end else if (wr_ctrl) begin
      edac_en  <= cfg_wdata[TC_EDAC_BIT];
      par_en   <= cfg_wdata[TC_PAR_BIT];
      cb_field <= cfg_wdata[CB_MSB:TC_CB_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sysav <= 1'b0;
    else if (wr_avail) sysav <= cfg_wdata[TC_AVAIL_BIT];
  end

  // Bits of the write word that no field decodes.
  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata[REG_W-1:CB_MSB+1], cfg_wdata[TC_CB_LSB-1:TC_PAR_BIT+1]};
endmodule

// File: rtl/memtest_ctl_store.sv
module memtest_ctl_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CB_W   = 7
) (
  input  logic              edac_en,
  input  logic [CB_W-1:0]   cb_field,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CB_W-1:0]   in_cb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CB_W-1:0]   out_cb
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = in_data;

  // Per-bit override multiplexer.
  for (genvar i = 0; i < CB_W; i++) begin : g_cb
    assign out_cb[i] = edac_en ? cb_field[i] : in_cb[i];
  end
endmodule

// File: rtl/memtest_ctl_rdpar.sv
module memtest_ctl_rdpar #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          ODD_PAR = 1'b1
) (
  input  logic              par_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par
);
  logic good_par;

  if (ODD_PAR) begin : g_odd
    assign good_par = ~(^in_data);
  end else begin : g_even
    assign good_par = ^in_data;
  end

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = in_data;
  assign out_par   = good_par ^ par_en;
endmodule

// File: rtl/memtest_ctl_avail.sv
module memtest_ctl_avail (
  input  logic clk,
  input  logic rst_n,
  input  logic sysav,
  input  logic sys_err_n,
  output logic avail_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_o <= 1'b0;
    else        avail_o <= sysav & sys_err_n;
  end
endmodule

// File: rtl/memtest_ctl.sv
module memtest_ctl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CB_W   = 7,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              sys_err_n,
  output logic              avail_o,
  input  logic              st_in_valid,
  output logic              st_in_ready,
  input  logic [DATA_W-1:0] st_in_data,
  input  logic [CB_W-1:0]   st_in_cb,
  output logic              st_out_valid,
  input  logic              st_out_ready,
  output logic [DATA_W-1:0] st_out_data,
  output logic [CB_W-1:0]   st_out_cb,
  input  logic              rd_in_valid,
  output logic              rd_in_ready,
  input  logic [DATA_W-1:0] rd_in_data,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [DATA_W-1:0] rd_out_data,
  output logic              rd_out_par
);
  logic            edac_en;
  logic            par_en;
  logic [CB_W-1:0] cb_field;
  logic            sysav;

  memtest_ctl_regs #(.REG_W(REG_W), .CB_W(CB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .edac_en(edac_en), .par_en(par_en),
    .cb_field(cb_field), .sysav(sysav)
  );

  memtest_ctl_store #(.DATA_W(DATA_W), .CB_W(CB_W)) u_store (
    .edac_en(edac_en), .cb_field(cb_field),
    .in_valid(st_in_valid), .in_ready(st_in_ready),
    .in_data(st_in_data), .in_cb(st_in_cb),
    .out_valid(st_out_valid), .out_ready(st_out_ready),
    .out_data(st_out_data), .out_cb(st_out_cb)
  );

  memtest_ctl_rdpar #(.DATA_W(DATA_W), .ODD_PAR(1'b1)) u_rdpar (
    .par_en(par_en),
    .in_valid(rd_in_valid), .in_ready(rd_in_ready), .in_data(rd_in_data),
    .out_valid(rd_out_valid), .out_ready(rd_out_ready),
    .out_data(rd_out_data), .out_par(rd_out_par)
  );

  memtest_ctl_avail u_avail (
    .clk(clk), .rst_n(rst_n), .sysav(sysav),
    .sys_err_n(sys_err_n), .avail_o(avail_o)
  );
endmodule

// File: rtl/memtest_ctl_chk.sv
module memtest_ctl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CB_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_err_n,
  input logic              avail_o,
  input logic              sysav,
  input logic              edac_en,
  input logic              par_en,
  input logic [CB_W-1:0]   cb_field,
  input logic              st_out_valid,
  input logic [CB_W-1:0]   st_in_cb,
  input logic [CB_W-1:0]   st_out_cb,
  input logic              rd_out_valid,
  input logic [DATA_W-1:0] rd_out_data,
  input logic              rd_out_par
);
  // R1: reset clears the availability output
  p_rst_avail_r1: assert property (@(posedge clk) !rst_n |=> !avail_o);

  // R2: output high only if error was absent and the flag was set one edge earlier
  p_avail_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> $past(sys_err_n));
  p_avail_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> $past(sysav));

  // R3: override field reaches memory
  p_cb_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_out_valid && edac_en) |-> (st_out_cb == cb_field));

  // R4: encoder checkbits pass untouched
  p_cb_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_out_valid && !edac_en) |-> (st_out_cb == st_in_cb));

  // R6: odd parity in normal mode
  p_par_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && !par_en) |-> (^{rd_out_data, rd_out_par}) == 1'b1);

  // R7: wrong parity in corruption mode
  p_par_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && par_en) |-> (^{rd_out_data, rd_out_par}) == 1'b0);
endmodule

bind memtest_ctl memtest_ctl_chk #(.DATA_W(DATA_W), .CB_W(CB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_err_n(sys_err_n), .avail_o(avail_o),
  .sysav(sysav), .edac_en(edac_en), .par_en(par_en), .cb_field(cb_field),
  .st_out_valid(st_out_valid), .st_in_cb(st_in_cb), .st_out_cb(st_out_cb),
  .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data), .rd_out_par(rd_out_par)
);

// File: tb/memtest_ctl_bench.sv
module memtest_ctl_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 7;
  localparam int unsigned RW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [RW-1:0] cfg_wdata = '0;
  logic          sys_err_n = 1'b1;
  logic          avail_o;
  logic          st_in_valid = 1'b0, st_in_ready, st_out_valid, st_out_ready = 1'b0;
  logic [DW-1:0] st_in_data = '0, st_out_data;
  logic [CW-1:0] st_in_cb = '0, st_out_cb;
  logic          rd_in_valid = 1'b0, rd_in_ready, rd_out_valid, rd_out_ready = 1'b0;
  logic [DW-1:0] rd_in_data = '0, rd_out_data;
  logic          rd_out_par;

  memtest_ctl #(.DATA_W(DW), .CB_W(CW), .REG_W(RW)) u_memtest_ctl (.*);

  int checks = 0;
  int fails  = 0;

  // Bench model of the programmed state
  logic          m_edac = 0, m_par = 0, m_sysav = 0, m_avail = 0;
  logic [CW-1:0] m_cb = '0;

  function automatic logic exp_par(input logic [DW-1:0] d, input logic corrupt);
    logic odd_bit;
    odd_bit = ~(^d);
    return corrupt ? ~odd_bit : odd_bit;
  endfunction

  function automatic logic [CW-1:0] exp_cb(input logic en, input logic [CW-1:0] fld,
                                           input logic [CW-1:0] enc);
    return en ? fld : enc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Check outputs mid-cycle, then cross one rising edge and update the model.
  task automatic step();
    #2;
    chk(avail_o == m_avail, "R2 avail_o", avail_o, m_avail);
    chk(st_out_valid == st_in_valid && st_in_ready == st_out_ready, "R5 store handshake",
        {st_out_valid, st_in_ready}, {st_in_valid, st_out_ready});
    chk(st_out_data == st_in_data, "R5 store data", st_out_data, st_in_data);
    chk(st_out_cb == exp_cb(m_edac, m_cb, st_in_cb), m_edac ? "R3 override cb" : "R4 pass cb",
        st_out_cb, exp_cb(m_edac, m_cb, st_in_cb));
    chk(rd_out_valid == rd_in_valid && rd_in_ready == rd_out_ready, "R8 read handshake",
        {rd_out_valid, rd_in_ready}, {rd_in_valid, rd_out_ready});
    chk(rd_out_data == rd_in_data, "R7 read data", rd_out_data, rd_in_data);
    chk(rd_out_par == exp_par(rd_in_data, m_par), m_par ? "R7 bad parity" : "R6 odd parity",
        rd_out_par, exp_par(rd_in_data, m_par));
    @(posedge clk);
    #1;
    m_avail = m_sysav & sys_err_n;
    if (cfg_we && cfg_addr == 1'b0) begin
      m_edac = cfg_wdata[0];
      m_par  = cfg_wdata[1];
      m_cb   = cfg_wdata[14:8];
    end else if (cfg_we && cfg_addr == 1'b1) begin
      m_sysav = cfg_wdata[0];
    end
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic a, input logic [RW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic drive_rand();
    cfg_we       = ($urandom % 4) == 0;
    cfg_addr     = $urandom % 2;
    cfg_wdata    = $urandom;
    sys_err_n    = ($urandom % 5) != 0;
    st_in_valid  = $urandom % 2;
    st_out_ready = $urandom % 2;
    st_in_data   = $urandom;
    st_in_cb     = CW'($urandom);
    rd_in_valid  = $urandom % 2;
    rd_out_ready = $urandom % 2;
    rd_in_data   = $urandom;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(avail_o == 1'b0, "R1 avail after reset", avail_o, 0);
    rst_n = 1'b1;
    st_in_valid = 1; st_out_ready = 1; st_in_cb = 7'h55; st_in_data = 32'hA5A5_0001;
    rd_in_valid = 1; rd_out_ready = 1; rd_in_data = 32'h0000_0003;
    #2;
    chk(st_out_cb == 7'h55, "R1 override off after reset", st_out_cb, 7'h55);
    chk(rd_out_par == 1'b1, "R1 parity corruption off after reset", rd_out_par, 1);
    @(negedge clk);

    // R9: stray bits outside the fields, flag untouched by control write
    write_cfg(1'b0, 32'hFFFF_80FD); // edac=1 par=0 cb=0x00
    step();
    chk(avail_o == 1'b0, "R9 control write leaves flag", avail_o, 0);
    st_in_cb = 7'h7F;
    step();                          // R3: field all zero overrides all ones
    write_cfg(1'b0, 32'h0000_2A03); // edac=1 par=1 cb=0x2A
    rd_in_data = 32'hFFFF_FFFF;
    step();
    // R9: strobe low changes nothing
    cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    step();
    step();
    chk(st_out_cb == 7'h2A, "R9 no write without strobe", st_out_cb, 7'h2A);

    // R2: flag set, error present then absent
    sys_err_n = 1'b0;
    write_cfg(1'b1, 32'h0000_0001);
    step();
    chk(avail_o == 1'b0, "R2 error blocks availability", avail_o, 0);
    sys_err_n = 1'b1;
    step();
    step();
    chk(avail_o == 1'b1, "R2 available with flag and no error", avail_o, 1);
    write_cfg(1'b1, 32'hFFFF_FFFE); // R9: flag cleared via bit 0 only
    step();
    chk(avail_o == 1'b0, "R9 flag cleared", avail_o, 0);
    write_cfg(1'b1, 32'h0000_0001);
    write_cfg(1'b0, 32'h0000_0000); // R4: override off
    step();

    // Random traffic
    for (int i = 0; i < 2000; i++) begin
      drive_rand();
      step();
    end

    // Reset in mid-run returns everything to zero
    rst_n = 1'b0;
    #2;
    chk(avail_o == 1'b0, "R1 avail on reset", avail_o, 0);
    m_edac = 0; m_par = 0; m_cb = '0; m_sysav = 0; m_avail = 0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_we = 1'b0;
    st_in_cb = 7'h33;
    step();
    chk(st_out_cb == 7'h33, "R1 override cleared by reset", st_out_cb, 7'h33);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule